// File: doc/BRIEF.md
# Prioritized Interrupt Vector Resolver

This block picks, from a set of pending exception and interrupt requests, the most urgent one that is not masked. It presents that source's 16-bit vector address and drives a short entry sequence for the core. The core stacks its registers, sets its interrupt mask and fetches the new program counter from the vector. Arbitration happens only when the core signals an instruction boundary. The winning source is held in a register until the entry sequence has finished.

The priority order is fixed. Index 0 is the highest priority, and source `i` owns the vector `$FFFE - 2*i`. The first five sources cannot be masked. Index 5 is the high-priority maskable source and is gated by the X mask bit. Every source from index 6 downward is gated by the I mask bit and by its own local enable bit. Software can move one I-gated source to the top of the I-gated group. It does this by writing the low byte of that source's vector into the promote register.

Top module: `ivr_resolver`

## Requirements
- R1: During and after reset, `take_o`, `stack_o` and `seti_o` are low and `vec_o` is `$FFFE`.
- R2: Among pending sources that are not masked, the lowest index wins. The output vector is `$FFFE - 2*index`, so source 0 gives `$FFFE` and source 22 gives `$FFD2`.
- R3: Sources 0 to 4 win when pending, whatever the values of `imask`, `xmask` and `lcl_en`.
- R4: Source 5 is taken only while `xmask` is 0, and it outranks every I-gated source, including a promoted one.
- R5: Source `i`, for i ≥ 6, is eligible only when `imask` is 0 and `lcl_en[i-6]` is 1.
- R6: If `promote` equals the low byte of an I-gated source's vector and that source is eligible, it wins over all other I-gated sources. For example, `$E6` promotes source 12.
- R7: A `promote` value that matches no I-gated vector leaves the order unchanged. This includes odd values, values outside `$D2`..`$F2`, and low bytes of non-maskable vectors.
- R8: Requests are sampled only on a clock edge where `boundary` is 1 and the sequencer is idle. Requests on any other edge are ignored.
- R9: After an accepted edge, `take_o` and `stack_o` are 1 for exactly one cycle. `seti_o` is 1 in the following cycle, and then all three return to 0.
- R10: If nothing is eligible at a sampling edge, `take_o` stays 0 and `vec_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 23 | Pending request per source, bit i = source i |
| lcl_en | input | 17 | Local enable for sources 6..22, bit k = source k+6 |
| imask | input | 1 | I mask bit, 1 masks sources 6..22 |
| xmask | input | 1 | X mask bit, 1 masks source 5 |
| boundary | input | 1 | Instruction-boundary strobe |
| promote | input | 8 | Low byte of the vector of the source to promote |
| vec_o | output | 16 | Latched vector address of the winner |
| take_o | output | 1 | One-cycle interrupt acceptance pulse |
| stack_o | output | 1 | Register stacking request |
| seti_o | output | 1 | Set-I command |

## Verification
Several properties are checked on every cycle. The acceptance pulse is always a single cycle and is always followed by the set-I command. The vector stays stable unless an acceptance occurs. A pending non-maskable request always produces a non-maskable winner. A boundary with nothing eligible never yields an acceptance. The exact vector chosen under each combination of masks, enables and promote values can only be shown by the bench's scenarios. The same holds for rejecting a boundary that arrives while the sequence is still running.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    parameter int N_SRC   = 23;
    parameter int FIRST_X = 5;
    parameter int FIRST_I = 6;
    parameter logic [15:0] TOP_VEC = 16'hFFFE;
    localparam int IDXW   = $clog2(N_SRC);
    localparam int N_IGAT = N_SRC - FIRST_I;

    typedef enum logic [1:0] {SQ_IDLE, SQ_STACK, SQ_SETI} seq_t;

    typedef struct packed {
        logic            valid;
        logic [IDXW-1:0] idx;
    } win_t;

    function automatic logic [15:0] vec_of(input int i);
        return TOP_VEC - 16'(2 * i);
    endfunction
endpackage

// File: rtl/ivr_mask.sv
module ivr_mask
    import ivr_pkg::*;
(
    input  logic [N_SRC-1:0]  req,
    input  logic [N_IGAT-1:0] lcl_en,
    input  logic              imask,
    input  logic              xmask,
    output logic [N_SRC-1:0]  elig
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (g < FIRST_X) begin : g_nm
            assign elig[g] = req[g];
        end else if (g < FIRST_I) begin : g_x
            assign elig[g] = req[g] & ~xmask;
        end else begin : g_i
            assign elig[g] = req[g] & ~imask & lcl_en[g-FIRST_I];
        end
    end
endmodule

// File: rtl/ivr_arbiter.sv
module ivr_arbiter
    import ivr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] elig,
    input  logic [7:0]       promote,
    output win_t             win
);
    logic [N_SRC-1:0] hit;

    for (genvar g = 0; g < N_SRC; g++) begin : g_hit
        if (g < FIRST_I) begin : g_no
            assign hit[g] = 1'b0;
        end else begin : g_yes
            localparam logic [15:0] V = vec_of(g);
            assign hit[g] = elig[g] && (promote == V[7:0]);
        end
    end

    always_comb begin
        win = '0;
        for (int i = N_SRC - 1; i >= FIRST_I; i--)
            if (elig[i]) begin win.valid = 1'b1; win.idx = IDXW'(i); end
        for (int i = N_SRC - 1; i >= FIRST_I; i--)
            if (hit[i]) begin win.valid = 1'b1; win.idx = IDXW'(i); end
        for (int i = FIRST_I - 1; i >= 0; i--)
            if (elig[i]) begin win.valid = 1'b1; win.idx = IDXW'(i); end
    end

    // R3
    nm_first_chk: assert property (@(posedge clk) disable iff (rst)
        (|elig[FIRST_I-2:0]) |-> (win.valid && win.idx < IDXW'(FIRST_X)));
    // R2
    none_chk: assert property (@(posedge clk) disable iff (rst)
        (elig == '0) |-> !win.valid);
endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
    import ivr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        boundary,
    input  win_t        win,
    output logic [15:0] vec_o,
    output logic        take_o,
    output logic        stack_o,
    output logic        seti_o
);
    seq_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_IDLE;
            vec_o <= TOP_VEC;
        end else begin
            case (st)
                SQ_IDLE: if (boundary && win.valid) begin
                    st    <= SQ_STACK;
                    vec_o <= TOP_VEC - {{(15-IDXW){1'b0}}, win.idx, 1'b0};
                end
                SQ_STACK: st <= SQ_SETI;
                default:  st <= SQ_IDLE;
            endcase
        end
    end

    assign take_o  = (st == SQ_STACK);
    assign stack_o = (st == SQ_STACK);
    assign seti_o  = (st == SQ_SETI);

    // R10
    no_win_chk: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE && boundary && !win.valid) |=> !take_o);
endmodule

// File: rtl/ivr_resolver.sv
module ivr_resolver
    import ivr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  req,
    input  logic [N_IGAT-1:0] lcl_en,
    input  logic              imask,
    input  logic              xmask,
    input  logic              boundary,
    input  logic [7:0]        promote,
    output logic [15:0]       vec_o,
    output logic              take_o,
    output logic              stack_o,
    output logic              seti_o
);
    logic [N_SRC-1:0] elig;
    win_t             win;

    ivr_mask u_mask (.req(req), .lcl_en(lcl_en), .imask(imask), .xmask(xmask), .elig(elig));
    ivr_arbiter u_arb (.clk(clk), .rst(rst), .elig(elig), .promote(promote), .win(win));
    ivr_seq u_seq (.clk(clk), .rst(rst), .boundary(boundary), .win(win), .vec_o(vec_o),
                   .take_o(take_o), .stack_o(stack_o), .seti_o(seti_o));

    // R9
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |=> (seti_o && !take_o && !stack_o));
    // R9
    seti_after_chk: assert property (@(posedge clk) disable iff (rst)
        seti_o |-> $past(take_o));
    // R10
    vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> $stable(vec_o));
    // R5
    all_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (imask && xmask && req[FIRST_X-1:0] == '0) |-> !win.valid);
endmodule

// File: tb/sim_ivr_resolver.sv
module sim_ivr_resolver;
    localparam int CLK_PER = 10;

    typedef struct packed {
        logic [22:0] req;
        logic [16:0] en;
        logic        im;
        logic        xm;
        logic [7:0]  pr;
        logic        tk;
        logic [15:0] vec;
    } row_t;

    localparam row_t TBL [16] = '{
        '{23'h000408, 17'h00000, 1'b1, 1'b1, 8'h00, 1'b1, 16'hFFF8}, // R3 R2
        '{23'h000003, 17'h00000, 1'b1, 1'b1, 8'h00, 1'b1, 16'hFFFE}, // R2
        '{23'h000020, 17'h00000, 1'b1, 1'b0, 8'h00, 1'b1, 16'hFFF4}, // R4
        '{23'h0000A0, 17'h1FFFF, 1'b0, 1'b1, 8'h00, 1'b1, 16'hFFF0}, // R4 masked
        '{23'h001080, 17'h1FFFF, 1'b0, 1'b1, 8'h00, 1'b1, 16'hFFF0}, // R5
        '{23'h001080, 17'h1FFFF, 1'b0, 1'b1, 8'hE6, 1'b1, 16'hFFE6}, // R6
        '{23'h001020, 17'h1FFFF, 1'b0, 1'b0, 8'hE6, 1'b1, 16'hFFF4}, // R4
        '{23'h001080, 17'h1FFFF, 1'b0, 1'b1, 8'hE7, 1'b1, 16'hFFF0}, // R7
        '{23'h001080, 17'h1FFFF, 1'b0, 1'b1, 8'hFA, 1'b1, 16'hFFF0}, // R7
        '{23'h001080, 17'h1FFFF, 1'b0, 1'b1, 8'h40, 1'b1, 16'hFFF0}, // R7
        '{23'h001000, 17'h1FFBF, 1'b0, 1'b1, 8'h00, 1'b0, 16'hFFF0}, // R5 R10
        '{23'h400000, 17'h1FFFF, 1'b0, 1'b1, 8'h00, 1'b1, 16'hFFD2}, // R2
        '{23'h400000, 17'h1FFFF, 1'b1, 1'b1, 8'h00, 1'b0, 16'hFFD2}, // R5 R10
        '{23'h400040, 17'h1FFFF, 1'b0, 1'b1, 8'hD2, 1'b1, 16'hFFD2}, // R6
        '{23'h000010, 17'h00000, 1'b1, 1'b1, 8'h00, 1'b1, 16'hFFF6}, // R3
        '{23'h000300, 17'h1FFFF, 1'b0, 1'b1, 8'hE6, 1'b1, 16'hFFEE}  // R6 idle target
    };

    logic        clk = 0, rst = 1;
    logic [22:0] req = '0;
    logic [16:0] lcl_en = '0;
    logic        imask = 1, xmask = 1, boundary = 0;
    logic [7:0]  promote = '0;
    logic [15:0] vec_o;
    logic        take_o, stack_o, seti_o;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    ivr_resolver u0 (.clk(clk), .rst(rst), .req(req), .lcl_en(lcl_en), .imask(imask),
                     .xmask(xmask), .boundary(boundary), .promote(promote), .vec_o(vec_o),
                     .take_o(take_o), .stack_o(stack_o), .seti_o(seti_o));

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic run_row(input row_t r, input int n);
        @(negedge clk);
        req = r.req; lcl_en = r.en; imask = r.im; xmask = r.xm; promote = r.pr;
        boundary = 1;
        @(negedge clk);
        boundary = 0;
        chk($sformatf("R2 row%0d take", n), 16'(take_o), 16'(r.tk));
        chk($sformatf("R2 row%0d vec", n), vec_o, r.vec);
        chk($sformatf("R9 row%0d stack", n), 16'(stack_o), 16'(r.tk));
        @(negedge clk);
        chk($sformatf("R9 row%0d seti", n), 16'(seti_o), 16'(r.tk));
        chk($sformatf("R9 row%0d take low", n), 16'(take_o), 16'h0);
        @(negedge clk);
        chk($sformatf("R9 row%0d idle", n), 16'({take_o, stack_o, seti_o}), 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 take", 16'(take_o), 16'h0);
        chk("R1 stack", 16'(stack_o), 16'h0);
        chk("R1 seti", 16'(seti_o), 16'h0);
        chk("R1 vec", vec_o, 16'hFFFE);
        rst = 0;
        for (int i = 0; i < 16; i++) run_row(TBL[i], i);

        // R8: request without a boundary is ignored
        @(negedge clk);
        req = 23'h000001; boundary = 0;
        @(negedge clk);
        chk("R8 no boundary", 16'(take_o), 16'h0);
        chk("R8 vec held", vec_o, 16'hFFEE);

        // R8: boundary during busy sequence ignored
        req = 23'h000004; boundary = 1;
        @(negedge clk);
        chk("R8 accept", vec_o, 16'hFFFA);
        req = 23'h000001;
        @(negedge clk);
        chk("R8 busy ignored", vec_o, 16'hFFFA);
        boundary = 0;
        @(negedge clk);
        chk("R8 no retake", 16'(take_o), 16'h0);
        chk("R8 vec after busy", vec_o, 16'hFFFA);

        // R1: reset mid-sequence
        req = 23'h000002; boundary = 1;
        @(negedge clk);
        boundary = 0; rst = 1;
        @(negedge clk);
        chk("R1 reset take", 16'(take_o), 16'h0);
        chk("R1 reset vec", vec_o, 16'hFFFE);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule